// File: doc/BRIEF.md
# Word Address Pointer for a Paged Serial Memory

This block keeps the word address that a two-wire serial memory controller uses for its next array access. The controller loads a fresh 16-bit address once it has received both address bytes of a command. After each data byte is stored or returned, the controller pulses a step strobe. The pointer then moves on by one.

Stores and fetches advance the pointer differently. A store moves only the byte offset inside the current 128-byte page, so a long burst folds back onto the start of the same page. A fetch moves the full address, so a long burst runs across page borders and wraps from the top of the array to address zero. Between transactions the pointer keeps the address that follows the last byte touched. A later read that carries no address therefore continues where the previous access stopped.

The pointer is a register. Every change shows on the output one clock edge after the strobe that caused it, and the output holds steady while no strobe is present.

Top module: `addr_ptr_unit`

## Requirements
- R1: While `rst_n` is low, `addr_o` is 0x0000. The clear is asynchronous.
- R2: With `load_i` high at a rising clock edge, `addr_o` shows `load_addr_i` after that edge.
- R3: A write step (`wr_step_i` high alone) adds one to bits 6:0 of `addr_o` and leaves bits 15:7 as they were. For example, 0x1234 becomes 0x1235.
- R4: A write step from page offset 127 (bits 6:0 all ones) gives offset 0 of the same page. For example, 0x237F becomes 0x2300, and 0xFFFF becomes 0xFF80.
- R5: A read step (`rd_step_i` high alone) adds one to the whole 16-bit address, carrying into the page bits. For example, 0x237F becomes 0x2380.
- R6: A read step from 0xFFFF gives 0x0000.
- R7: When `load_i` is high in the same cycle as either step strobe, the load takes effect and the step is dropped.
- R8: When both step strobes are high without a load, the write rule applies. For example, 0x007F becomes 0x0000, not 0x0080.
- R9: With no strobe high, `addr_o` keeps its value on every edge, so the value after the last access survives between transactions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load strobe for a new word address |
| load_addr_i | input | 16 | Address taken when `load_i` is high |
| wr_step_i | input | 1 | Step strobe after a byte is stored (in-page wrap) |
| rd_step_i | input | 1 | Step strobe after a byte is fetched (whole-array wrap) |
| addr_o | output | 16 | Registered current word address |

## Verification
Every load and step result is due at `addr_o` exactly one rising edge after the strobe is sampled. The only exception is the reset clear, which is due at once. The bench drives each strobe for one cycle from the falling edge and removes it just after the following rising edge. It then compares `addr_o` one time unit later, so each compare falls between that edge and the next. The hold checks sample once after each of several idle edges, so a value that drifts one cycle late is still caught.

// File: rtl/addr_ptr_pkg.sv
package addr_ptr_pkg;

   // Which update the pointer register takes on the coming edge.
   typedef enum logic [1:0] {
      UPD_HOLD  = 2'd0,
      UPD_LOAD  = 2'd1,
      UPD_PAGE  = 2'd2,
      UPD_WHOLE = 2'd3
   } upd_kind_e;

endpackage

// File: rtl/addr_ptr_page_inc.sv
// Adds one inside the low OFS_W bits only; the upper bits pass unchanged.
module addr_ptr_page_inc #(
   parameter int ADDR_W = 16,
   parameter int OFS_W  = 7
) (
   input  logic [ADDR_W-1:0] cur_i,
   output logic [ADDR_W-1:0] nxt_o
);
   localparam int ROW_W = ADDR_W - OFS_W;

   logic [OFS_W-1:0] ofs_nxt;
   assign ofs_nxt = cur_i[OFS_W-1:0] + {{(OFS_W-1){1'b0}}, 1'b1};

   generate
      if (ROW_W == 0) begin : g_single_page
         assign nxt_o = ofs_nxt;
      end else begin : g_multi_page
         assign nxt_o = {cur_i[ADDR_W-1:OFS_W], ofs_nxt};
      end
   endgenerate
endmodule

// File: rtl/addr_ptr_full_inc.sv
// Adds one across the whole address; wraps from all ones to zero.
module addr_ptr_full_inc #(
   parameter int ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] cur_i,
   output logic [ADDR_W-1:0] nxt_o
);
   assign nxt_o = cur_i + {{(ADDR_W-1){1'b0}}, 1'b1};
endmodule

// File: rtl/addr_ptr_arbiter.sv
// Priority: load, then write step, then read step.
module addr_ptr_arbiter
   import addr_ptr_pkg::*;
(
   input  logic      load_i,
   input  logic      wr_step_i,
   input  logic      rd_step_i,
   output upd_kind_e kind_o
);
   always_comb begin
      if (load_i)         kind_o = UPD_LOAD;
      else if (wr_step_i) kind_o = UPD_PAGE;
      else if (rd_step_i) kind_o = UPD_WHOLE;
      else                kind_o = UPD_HOLD;
   end
endmodule

// File: rtl/addr_ptr_unit.sv
module addr_ptr_unit
   import addr_ptr_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int PAGE_BITS = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] load_addr_i,
   input  logic              wr_step_i,
   input  logic              rd_step_i,
   output logic [ADDR_W-1:0] addr_o
);
   localparam int                PAGE_COUNT = 1 << (ADDR_W - PAGE_BITS);
   localparam logic [ADDR_W-1:0] RESET_ADDR = '0;

   generate
      if (PAGE_BITS < 1 || PAGE_BITS > ADDR_W) begin : g_bad_cfg
         $error("addr_ptr_unit: PAGE_BITS must be between 1 and ADDR_W");
      end
      if (PAGE_COUNT < 1) begin : g_bad_pages
         $error("addr_ptr_unit: page count must be at least one");
      end
   endgenerate

   logic [ADDR_W-1:0] ptr_q;
   logic [ADDR_W-1:0] ptr_d;
   logic [ADDR_W-1:0] page_nxt;
   logic [ADDR_W-1:0] whole_nxt;
   upd_kind_e         kind;

   addr_ptr_arbiter u_arb (
      .load_i    (load_i),
      .wr_step_i (wr_step_i),
      .rd_step_i (rd_step_i),
      .kind_o    (kind)
   );

   addr_ptr_page_inc #(.ADDR_W(ADDR_W), .OFS_W(PAGE_BITS)) u_page_inc (
      .cur_i (ptr_q),
      .nxt_o (page_nxt)
   );

   addr_ptr_full_inc #(.ADDR_W(ADDR_W)) u_full_inc (
      .cur_i (ptr_q),
      .nxt_o (whole_nxt)
   );

   always_comb begin
      unique case (kind)
         UPD_LOAD:  ptr_d = load_addr_i;
         UPD_PAGE:  ptr_d = page_nxt;
         UPD_WHOLE: ptr_d = whole_nxt;
         default:   ptr_d = ptr_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr_q <= RESET_ADDR;
      else        ptr_q <= ptr_d;
   end

   assign addr_o = ptr_q;
endmodule

// File: rtl/addr_ptr_unit_chk.sv
module addr_ptr_unit_chk #(
   parameter int ADDR_W    = 16,
   parameter int PAGE_BITS = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              load_i,
   input logic [ADDR_W-1:0] load_addr_i,
   input logic              wr_step_i,
   input logic              rd_step_i,
   input logic [ADDR_W-1:0] addr_o
);
   localparam logic [PAGE_BITS-1:0] OFS_TOP = '1;
   localparam logic [ADDR_W-1:0]    ADDR_TOP = '1;

   // R1: the register comes out of reset at zero
   a_r1_reset_zero: assert property (@(posedge clk)
      !rst_n |=> addr_o == '0);

   // R2: a load shows on the next edge
   a_r2_load_taken: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> addr_o == $past(load_addr_i));

   // R3: a write step keeps the page bits
   a_r3_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_step_i && !load_i) |=>
         addr_o[ADDR_W-1:PAGE_BITS] == $past(addr_o[ADDR_W-1:PAGE_BITS]));

   // R4: a write step from the last offset lands on offset zero
   a_r4_page_fold: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_step_i && !load_i && addr_o[PAGE_BITS-1:0] == OFS_TOP) |=>
         addr_o[PAGE_BITS-1:0] == '0);

   // R5: a read step advances the whole address by one
   a_r5_whole_step: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_step_i && !wr_step_i && !load_i) |=>
         addr_o == ADDR_W'($past(addr_o) + 1'b1));

   // R6: a read step from the top address gives zero
   a_r6_array_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_step_i && !wr_step_i && !load_i && addr_o == ADDR_TOP) |=>
         addr_o == '0);

   // R7: a load beats any step strobe
   a_r7_load_first: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && (wr_step_i || rd_step_i)) |=> addr_o == $past(load_addr_i));

   // R8: with both steps requested, the page bits stay
   a_r8_write_first: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_step_i && rd_step_i && !load_i) |=>
         addr_o[ADDR_W-1:PAGE_BITS] == $past(addr_o[ADDR_W-1:PAGE_BITS]));

   // R9: no strobe leaves the address alone
   a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !wr_step_i && !rd_step_i) |=> $stable(addr_o));
endmodule

bind addr_ptr_unit addr_ptr_unit_chk #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_chk (.*);

// File: tb/addr_ptr_unit_tb.sv
module addr_ptr_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load_i = 1'b0;
   logic [15:0] load_addr_i = '0;
   logic        wr_step_i = 1'b0;
   logic        rd_step_i = 1'b0;
   logic [15:0] addr_o;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   addr_ptr_unit u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (load_i),
      .load_addr_i (load_addr_i),
      .wr_step_i   (wr_step_i),
      .rd_step_i   (rd_step_i),
      .addr_o      (addr_o)
   );

   task automatic check(input string req, input logic [15:0] exp);
      n_checks++;
      if (addr_o !== exp) begin
         n_fails++;
         $display("FAIL %s: addr_o=%h expected %h", req, addr_o, exp);
      end
   endtask

   // One-cycle strobe: driven at the falling edge, removed after the rising edge.
   task automatic pulse(input logic ld, input logic [15:0] a, input logic w, input logic r);
      @(negedge clk);
      load_i = ld; load_addr_i = a; wr_step_i = w; rd_step_i = r;
      @(posedge clk);
      #1;
      load_i = 1'b0; wr_step_i = 1'b0; rd_step_i = 1'b0;
   endtask

   task automatic t_reset();
      #1 check("R1", 16'h0000);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1 check("R1", 16'h0000);
   endtask

   task automatic t_load_and_write();
      pulse(1'b1, 16'h1234, 1'b0, 1'b0); check("R2", 16'h1234);
      pulse(1'b0, 16'h0000, 1'b1, 1'b0); check("R3", 16'h1235);
   endtask

   task automatic t_page_fold();
      pulse(1'b1, 16'h237E, 1'b0, 1'b0); check("R2", 16'h237E);
      pulse(1'b0, 16'h0000, 1'b1, 1'b0); check("R3", 16'h237F);
      pulse(1'b0, 16'h0000, 1'b1, 1'b0); check("R4", 16'h2300);
      pulse(1'b0, 16'h0000, 1'b1, 1'b0); check("R3", 16'h2301);
      pulse(1'b1, 16'hFFFF, 1'b0, 1'b0);
      pulse(1'b0, 16'h0000, 1'b1, 1'b0); check("R4", 16'hFF80);
   endtask

   task automatic t_read_steps();
      pulse(1'b1, 16'h237F, 1'b0, 1'b0);
      pulse(1'b0, 16'h0000, 1'b0, 1'b1); check("R5", 16'h2380);
      pulse(1'b0, 16'h0000, 1'b0, 1'b1); check("R5", 16'h2381);
      pulse(1'b1, 16'hFFFF, 1'b0, 1'b0);
      pulse(1'b0, 16'h0000, 1'b0, 1'b1); check("R6", 16'h0000);
   endtask

   task automatic t_priority();
      pulse(1'b1, 16'h0040, 1'b0, 1'b0);
      pulse(1'b1, 16'hABCD, 1'b1, 1'b0); check("R7", 16'hABCD);
      pulse(1'b1, 16'h5555, 1'b0, 1'b1); check("R7", 16'h5555);
      pulse(1'b1, 16'h007F, 1'b0, 1'b0);
      pulse(1'b0, 16'h0000, 1'b1, 1'b1); check("R8", 16'h0000);
   endtask

   task automatic t_idle_hold();
      pulse(1'b1, 16'h3C7A, 1'b0, 1'b0);
      pulse(1'b0, 16'h0000, 1'b0, 1'b1); check("R5", 16'h3C7B);
      load_addr_i = 16'h9999;
      for (int i = 0; i < 5; i++) begin
         @(posedge clk); #1 check("R9", 16'h3C7B);
      end
   endtask

   task automatic t_reset_midway();
      @(negedge clk); rst_n = 1'b0;
      #1 check("R1", 16'h0000);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1 check("R1", 16'h0000);
   endtask

   initial begin
      t_reset();
      t_load_and_write();
      t_page_fold();
      t_read_steps();
      t_priority();
      t_idle_hold();
      t_reset_midway();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
         end
      join_any
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
   end
endmodule